// File: doc/BRIEF.md
# Skewed Triangular Factor Store

This block holds one lower-triangular matrix of up to P by P elements in P single-port banks, one bank per parallel lane. A single copy serves two access shapes: one request returns a whole column or a whole row of the triangle across the P output lanes. There is no second, transposed copy. Element (i, j), with j not above i, lives in bank (i + j) mod P at word j. A column read sends the same word address to every bank. A row read gives each bank its own address, (b - t) mod P. A circular rotation on the registered bank outputs then puts element order back into lane order.

Every output lane carries a lane-valid bit. Lanes that fall outside the triangle, or outside the active size k, are cleared. In the default build their data is forced to zero. Single elements are loaded through a write port that uses the same mapping. A write that targets a position above the diagonal is refused and flagged. A typical client fills the factor one element at a time. It then streams column reads for forward substitution and row reads for back substitution, and uses the lane-valid mask to gate its arithmetic.

Top module: `tri_shuffle_mem`

## Requirements
- R1: After reset, rd_valid, every bit of rd_lane_ok and wr_err are all 0.
- R2: A column read (rd_mode = 0) of index t, issued with rd_en in cycle N, returns in cycle N+1 the element at row L, column t on lane L, for every lane L with t ≤ L < k. Lane L occupies bits [L*DW +: DW] of rd_data.
- R3: A row read (rd_mode = 1) of index t with t < k returns, one cycle after the request, the element at row t, column L on lane L, for every lane L ≤ t.
- R4: rd_lane_ok[L] is 1 only for lanes inside the triangle and inside the size k. A cleared lane carries data 0. When t ≥ k, every lane is cleared. A cfg_size value above P acts as P. While rd_valid is 0, rd_lane_ok is all zero.
- R5: An accepted write of (row i, column j) with j ≤ i replaces that element. Later row reads of i and column reads of j return the new value, and no other element changes.
- R6: A write with column greater than row raises wr_err in the following cycle and leaves all stored elements unchanged. An accepted write leaves wr_err at 0.
- R7: When an accepted write and a read occur in the same cycle, the write completes. The output lane fed by the written bank, lane (i + j - t) mod P, is reported invalid with data 0. Every other lane returns its normal value.
- R8: rd_valid is 1 exactly in the cycle after a cycle with rd_en high, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | Read request |
| rd_mode | input | 1 | 0 = column read, 1 = row read |
| rd_idx | input | log2(P) | Column or row index t |
| cfg_size | input | log2(P)+1 | Active matrix size k (values above P act as P) |
| wr_en | input | 1 | Single-element write request |
| wr_row | input | log2(P) | Row i of the written element |
| wr_col | input | log2(P) | Column j of the written element |
| wr_data | input | DW | Write data |
| rd_valid | output | 1 | Read result present this cycle |
| rd_data | output | P*DW | Read vector, lane L at bits [L*DW +: DW] |
| rd_lane_ok | output | P | Per-lane valid mask |
| wr_err | output | 1 | Previous cycle's write was refused |

## Verification
Every result of this block is due exactly one cycle after its request. The read vector, lane mask and rd_valid appear one edge after rd_en, and wr_err appears one edge after wr_en. The bench therefore drives each request on a falling edge, waits through one rising edge, and samples on the next falling edge. It then drops the request and samples again one cycle later, to confirm that rd_valid and the mask have returned to zero. A collision read is sampled in the same slot. Its effect on the stored element is checked by a fresh read that is issued afterwards.

// File: rtl/tri_bank_pkg.sv
package tri_bank_pkg;
   typedef enum logic {
      ACC_COL = 1'b0,
      ACC_ROW = 1'b1
   } acc_mode_e;

   function automatic bit is_pow2(input int v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/tri_bank_addr_gen.sv
module tri_bank_addr_gen
   import tri_bank_pkg::*;
#(
   parameter int P  = 8,
   parameter int IW = $clog2(P)
) (
   input  acc_mode_e              mode,
   input  logic [IW-1:0]          idx,
   output logic [P-1:0][IW-1:0]   bank_addr
);
   for (genvar b = 0; b < P; b++) begin : g_bank
      // column: every bank at word t; row: bank b at word (b - t) mod P
      assign bank_addr[b] = (mode == ACC_COL) ? idx : (IW'(b) - idx);
   end
endmodule

// File: rtl/tri_bank_ram.sv
module tri_bank_ram #(
   parameter int DEPTH = 8,
   parameter int DW    = 16,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          en,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (en) begin
         if (we) mem[addr] <= wdata;
         else    rdata     <= mem[addr];
      end
   end
endmodule

// File: rtl/tri_lane_rotator.sv
module tri_lane_rotator #(
   parameter int P  = 8,
   parameter int DW = 16,
   parameter int IW = $clog2(P)
) (
   input  logic [P-1:0][DW-1:0] din,
   input  logic [IW-1:0]        shift,
   output logic [P-1:0][DW-1:0] dout
);
   for (genvar l = 0; l < P; l++) begin : g_lane
      // output lane l takes bank (l + shift) mod P
      assign dout[l] = din[IW'(l) + shift];
   end
endmodule

// File: rtl/tri_shuffle_mem.sv
module tri_shuffle_mem
   import tri_bank_pkg::*;
#(
   parameter int P            = 8,
   parameter int DW           = 16,
   parameter bit ZERO_INVALID = 1'b1,
   localparam int IW          = $clog2(P),
   localparam int SW          = IW + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rd_en,
   input  logic            rd_mode,
   input  logic [IW-1:0]   rd_idx,
   input  logic [SW-1:0]   cfg_size,
   input  logic            wr_en,
   input  logic [IW-1:0]   wr_row,
   input  logic [IW-1:0]   wr_col,
   input  logic [DW-1:0]   wr_data,
   output logic            rd_valid,
   output logic [P*DW-1:0] rd_data,
   output logic [P-1:0]    rd_lane_ok,
   output logic            wr_err
);
   // elaboration-time parameter checks
   if (!is_pow2(P)) begin : g_bad_p
      $error("tri_shuffle_mem: P must be a power of two and at least 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("tri_shuffle_mem: DW must be positive");
   end

   acc_mode_e              mode_in;
   logic                   wr_accept;
   logic [IW-1:0]          wr_bank;
   logic [SW-1:0]          size_eff;
   logic [P-1:0][IW-1:0]   rd_addr;
   logic [P-1:0]           bank_we;
   logic [P-1:0]           bank_en;
   logic [P-1:0][IW-1:0]   bank_addr;
   logic [P-1:0][DW-1:0]   bank_rdata;
   logic [P-1:0][DW-1:0]   lane_data;

   acc_mode_e              mode_q;
   logic [IW-1:0]          idx_q;
   logic [SW-1:0]          size_q;
   logic [P-1:0]           blocked_q;
   logic                   valid_q;
   logic                   err_q;

   assign mode_in   = acc_mode_e'(rd_mode);
   assign wr_accept = wr_en && (wr_col <= wr_row);
   assign wr_bank   = wr_row + wr_col;
   assign size_eff  = (cfg_size > SW'(P)) ? SW'(P) : cfg_size;

   tri_bank_addr_gen #(.P(P), .IW(IW)) u_addr (
      .mode      (mode_in),
      .idx       (rd_idx),
      .bank_addr (rd_addr)
   );

   for (genvar b = 0; b < P; b++) begin : g_bank
      assign bank_we[b]   = wr_accept && (wr_bank == IW'(b));
      assign bank_en[b]   = bank_we[b] || rd_en;
      assign bank_addr[b] = bank_we[b] ? wr_col : rd_addr[b];

      tri_bank_ram #(.DEPTH(P), .DW(DW), .AW(IW)) u_ram (
         .clk   (clk),
         .en    (bank_en[b]),
         .we    (bank_we[b]),
         .addr  (bank_addr[b]),
         .wdata (wr_data),
         .rdata (bank_rdata[b])
      );
   end

   // request context registered alongside the bank data
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q   <= 1'b0;
         err_q     <= 1'b0;
         mode_q    <= ACC_COL;
         idx_q     <= '0;
         size_q    <= '0;
         blocked_q <= '0;
      end else begin
         valid_q <= rd_en;
         err_q   <= wr_en && !wr_accept;
         if (rd_en) begin
            mode_q    <= mode_in;
            idx_q     <= rd_idx;
            size_q    <= size_eff;
            blocked_q <= bank_we;
         end
      end
   end

   tri_lane_rotator #(.P(P), .DW(DW), .IW(IW)) u_rot (
      .din   (bank_rdata),
      .shift (idx_q),
      .dout  (lane_data)
   );

   for (genvar l = 0; l < P; l++) begin : g_lane
      localparam logic [SW-1:0] LW = SW'(l);
      logic [IW-1:0] src_bank;
      logic          col_in;
      logic          row_in;
      logic          ok;

      assign src_bank = IW'(l) + idx_q;
      assign col_in   = (LW >= {1'b0, idx_q}) && (LW < size_q);
      assign row_in   = (LW <= {1'b0, idx_q}) && ({1'b0, idx_q} < size_q);
      assign ok       = valid_q && !blocked_q[src_bank] &&
                        ((mode_q == ACC_COL) ? col_in : row_in);
      assign rd_lane_ok[l] = ok;

      if (ZERO_INVALID) begin : g_zero
         assign rd_data[l*DW +: DW] = ok ? lane_data[l] : '0;
      end else begin : g_pass
         assign rd_data[l*DW +: DW] = lane_data[l];
      end
   end

   assign rd_valid = valid_q;
   assign wr_err   = err_q;

   // assertions
   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |-> (!rd_valid && !wr_err && rd_lane_ok == '0)); // R1

   AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid); // R8

   AST_NO_VALID_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid); // R8

   AST_LANES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> (rd_lane_ok == '0)); // R4

   AST_UPPER_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_col > wr_row)) |=> wr_err); // R6

   AST_UPPER_WRITE_NO_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_col > wr_row)) |-> (bank_we == '0)); // R6

   AST_ONE_BANK_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_we)); // R5

   AST_COLLISION_LANE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && wr_accept) |=> ($countones(rd_lane_ok) < P)); // R7
endmodule

// File: tb/tri_shuffle_mem_tb.sv
`timescale 1ns/1ps
module tri_shuffle_mem_tb;
   localparam int P  = 8;
   localparam int DW = 16;
   localparam int IW = $clog2(P);
   localparam int SW = IW + 1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            rd_en = 1'b0;
   logic            rd_mode = 1'b0;
   logic [IW-1:0]   rd_idx = '0;
   logic [SW-1:0]   cfg_size = SW'(P);
   logic            wr_en = 1'b0;
   logic [IW-1:0]   wr_row = '0;
   logic [IW-1:0]   wr_col = '0;
   logic [DW-1:0]   wr_data = '0;
   logic            rd_valid;
   logic [P*DW-1:0] rd_data;
   logic [P-1:0]    rd_lane_ok;
   logic            wr_err;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [DW-1:0] model [P][P];

   always #2 clk = ~clk;

   tri_shuffle_mem #(.P(P), .DW(DW)) u_dut (
      .clk, .rst_n, .rd_en, .rd_mode, .rd_idx, .cfg_size,
      .wr_en, .wr_row, .wr_col, .wr_data,
      .rd_valid, .rd_data, .rd_lane_ok, .wr_err
   );

   task automatic chk(input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pat(input int g, input int i, input int j);
      return DW'(g * 4096 + i * 16 + j + 1);
   endfunction

   // write one element; caller is at a falling edge
   task automatic do_write(input int i, input int j, input logic [DW-1:0] d);
      bit bad = (j > i);
      wr_en = 1'b1; wr_row = IW'(i); wr_col = IW'(j); wr_data = d;
      @(negedge clk);
      chk(bad ? "R6" : "R5", $sformatf("wr_err (%0d,%0d)", i, j), wr_err, bad);
      wr_en = 1'b0;
      if (!bad) model[i][j] = d;
   endtask

   // read with optional simultaneous write; caller is at a falling edge
   task automatic do_read(input string tag, input int mode, input int t, input int ksz,
                          input bit cw, input int wi, input int wj, input logic [DW-1:0] wd);
      int keff = (ksz > P) ? P : ksz;
      int blk = -1;
      rd_en = 1'b1; rd_mode = mode[0]; rd_idx = IW'(t); cfg_size = SW'(ksz);
      if (cw) begin
         wr_en = 1'b1; wr_row = IW'(wi); wr_col = IW'(wj); wr_data = wd;
         if (wj <= wi) blk = (((wi + wj) % P) - t + P) % P;
      end
      @(negedge clk);
      chk("R8", "rd_valid after request", rd_valid, 1);
      for (int l = 0; l < P; l++) begin
         bit ok;
         logic [DW-1:0] ev;
         if (mode == 0) ok = (l >= t) && (l < keff);
         else           ok = (l <= t) && (t < keff);
         if (l == blk) ok = 0;
         ev = ok ? ((mode == 0) ? model[l][t] : model[t][l]) : '0;
         chk(ok ? tag : "R4", $sformatf("lane_ok m%0d t%0d k%0d lane%0d", mode, t, ksz, l),
             rd_lane_ok[l], ok);
         chk(ok ? tag : "R4", $sformatf("data m%0d t%0d k%0d lane%0d", mode, t, ksz, l),
             rd_data[l*DW +: DW], ev);
      end
      rd_en = 1'b0; wr_en = 1'b0;
      if (cw && wj <= wi) model[wi][wj] = wd;
      @(negedge clk);
      chk("R8", "rd_valid idle", rd_valid, 0);
      chk("R4", "lane mask idle", rd_lane_ok, 0);
   endtask

   task automatic sweep(input string ctag, input string rtag, input int ksz);
      for (int t = 0; t < P; t++) begin
         do_read(ctag, 0, t, ksz, 0, 0, 0, '0);
         do_read(rtag, 1, t, ksz, 0, 0, 0, '0);
      end
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "rd_valid in reset", rd_valid, 0);
      chk("R1", "lane mask in reset", rd_lane_ok, 0);
      chk("R1", "wr_err in reset", wr_err, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "rd_valid after reset", rd_valid, 0);
      chk("R1", "wr_err after reset", wr_err, 0);

      // fill the whole triangle
      for (int i = 0; i < P; i++)
         for (int j = 0; j <= i; j++)
            do_write(i, j, pat(1, i, j));

      // every size, every index, both shapes
      for (int k = 0; k <= P; k++) sweep("R2", "R3", k);
      sweep("R2", "R3", 15);                     // oversize acts as P (R4)

      // writes above the diagonal must be refused
      for (int i = 0; i < P; i++)
         for (int j = i + 1; j < P; j++)
            do_write(i, j, pat(9, i, j));
      sweep("R6", "R6", P);

      // overwrite a scattered subset and re-check
      for (int i = 0; i < P; i++) do_write(i, (i * 3) % (i + 1), pat(2, i, i));
      sweep("R5", "R5", P);

      // write colliding with a read
      do_read("R7", 0, 2, P, 1, 5, 2, 16'hA5A5);
      do_read("R7", 1, 6, P, 1, 6, 3, 16'h5A5A);
      do_read("R7", 0, 0, P, 1, 7, 7, 16'h1234);
      do_read("R7", 1, 3, P, 1, 4, 4, 16'h4321);
      do_read("R7", 0, 1, P, 1, 1, 6, 16'hFFFF); // refused write: no lane dropped
      sweep("R7", "R7", P);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule